// File: doc/BRIEF.md
# Word-Serial CRC-32 Checksum Engine with Compare

This block computes a 32-bit cyclic redundancy checksum over a message of any byte length. The message arrives as 32-bit words, one per cycle, on a valid/ready input. A last flag marks the final word, and a two-bit count gives how many bytes of that word are valid. The checksum register starts from all ones at the start of every message. When the final word is only partly filled, the unused byte lanes are replaced with zeros and the whole word is folded in. No length field is folded in after the data, and no final complement is applied.

When the final word has been taken, the block stops accepting input for one cycle. In that cycle it raises a one-cycle done pulse and presents the checksum. The result stays on the output until the next message completes.

An expected checksum can be loaded beforehand. If checking is enabled during the done cycle and the result differs from the expected value, a mismatch interrupt flag is raised. The flag stays set until it is explicitly cleared. The block handles one message at a time and then returns to idle.

Top module: `crcw_engine`

## Requirements
- R1: The checksum register holds 0xFFFFFFFF at the start of every message: after reset and again after every done cycle.
- R2: Each accepted word updates the checksum with the polynomial 0x04C11DB7 in non-reflected form. The word is processed from bit 31 down to bit 0, so byte 0 sits in bits 31:24. One word is absorbed per cycle, and the output is the raw register value with no final complement.
- R3: On the word with in_last=1, in_bytes gives the valid byte count: 0 means 4 bytes, and 1, 2 or 3 mean that many bytes starting from bits 31:24. Lanes that are not valid are forced to zero before the update, whatever in_data holds there. On words that are not last, in_bytes is ignored.
- R4: No message length is appended. A message whose padded words are identical gives an identical checksum whatever its byte count.
- R5: done is high for exactly one cycle, the cycle after the last word is accepted. During that cycle crc_out shows the checksum, and crc_out then holds that value unchanged until the next done. Before the first message, crc_out is 0.
- R6: in_ready is high while idle. It is low from the cycle after the last word is accepted through the done cycle. Words offered while in_ready is low are ignored.
- R7: A pulse on exp_load stores exp_value as the expected checksum. If chk_en is high in the done cycle and the checksum differs from the stored value, irq is high from the next cycle on. If chk_en is low, or the values match, irq is not set.
- R8: irq stays high until irq_clr is pulsed, and it is low in the cycle after that pulse. Starting or finishing a new message does not clear it. A mismatch in the same cycle as irq_clr leaves irq set.
- R9: A synchronous reset (rst high at a clock edge) returns the block to idle: in_ready high, done low, irq low, crc_out 0, and the register reloaded to all ones, even in the middle of a message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block accepts a word this cycle |
| in_data | input | 32 | Input word, byte 0 in bits 31:24 |
| in_last | input | 1 | Word is the final word of the message |
| in_bytes | input | 2 | Valid byte count of the final word (0 means 4) |
| chk_en | input | 1 | Compare the result in the done cycle |
| exp_load | input | 1 | Store exp_value as the expected checksum |
| exp_value | input | 32 | Expected checksum |
| irq_clr | input | 1 | Clear the mismatch interrupt |
| done | output | 1 | One-cycle result-valid pulse |
| crc_out | output | 32 | Checksum result |
| irq | output | 1 | Sticky mismatch interrupt |

## Verification
Each result is checked against a byte-serial reference model in the bench. The single-word message tests the polynomial and the bit order on their own. Multi-word messages, sent both back to back and with idle gaps, show that chaining and stalls are handled. Final words with 1, 2 and 3 valid bytes carry junk in the unused lanes, so they separate real zero-padding from passing the input through. A one-byte message is compared with the same byte sent as a full zero-filled word, which shows that no length is folded in. The same message is repeated, and a reset is applied mid-message, to show that the preset is reloaded each time. Matching, mismatching and disabled compares, together with clears issued alone and in the same cycle as a mismatch, separate the set, hold and clear behaviour of the interrupt.

// File: rtl/crcw_pkg.sv
package crcw_pkg;

  localparam int CRC_W  = 32;
  localparam int LANE_W = 8;
  localparam int LANES  = CRC_W / LANE_W;
  localparam int CNT_W  = $clog2(LANES);

  typedef enum logic {ST_IDLE, ST_REPORT} crcw_state_e;

  // Fold one full word into the checksum, most significant bit first.
  function automatic logic [CRC_W-1:0] crc_fold_word(
    input logic [CRC_W-1:0] crc,
    input logic [CRC_W-1:0] word,
    input logic [CRC_W-1:0] poly
  );
    logic [CRC_W-1:0] c;
    logic             fb;
    c = crc;
    for (int b = CRC_W - 1; b >= 0; b--) begin
      fb = c[CRC_W-1] ^ word[b];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

  // Lane i (0 = bits 31:24) is kept unless it lies beyond the byte count
  // of a final word.
  function automatic logic lane_kept(
    input int              lane,
    input logic            last,
    input logic [CNT_W-1:0] cnt
  );
    if (!last || cnt == '0) return 1'b1;
    return lane < int'(cnt);
  endfunction

endpackage

// File: rtl/crcw_pad.sv
module crcw_pad
  import crcw_pkg::*;
(
  input  logic [CRC_W-1:0] word_in,
  input  logic             last,
  input  logic [CNT_W-1:0] cnt,
  output logic [CRC_W-1:0] word_out
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int HI = CRC_W - 1 - i * LANE_W;
    logic keep;
    assign keep = lane_kept(i, last, cnt);
    assign word_out[HI -: LANE_W] = keep ? word_in[HI -: LANE_W] : '0;
  end

endmodule

// File: rtl/crcw_core.sv
module crcw_core
  import crcw_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY   = 32'h04C1_1DB7,
  parameter logic [CRC_W-1:0] PRESET = 32'hFFFF_FFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic             reload,
  input  logic [CRC_W-1:0] word,
  output logic [CRC_W-1:0] crc_q
);

  logic [CRC_W-1:0] crc_next;
  assign crc_next = crc_fold_word(crc_q, word, POLY);

  always_ff @(posedge clk) begin
    if (rst || reload) crc_q <= PRESET;
    else if (upd)      crc_q <= crc_next;
  end

  // R1: register is back at the preset after a reload
  a_r1_preset_reload: assert property (@(posedge clk) disable iff (rst)
    reload |=> (crc_q == PRESET));

  // R2: an update without reload changes the register to the folded value
  a_r2_update_moves: assert property (@(posedge clk) disable iff (rst)
    (upd && !reload) |=> (crc_q == $past(crc_next)));

endmodule

// File: rtl/crcw_cmp.sv
module crcw_cmp
  import crcw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             exp_load,
  input  logic [CRC_W-1:0] exp_value,
  input  logic             check,
  input  logic [CRC_W-1:0] result,
  input  logic             irq_clr,
  output logic             mismatch_evt,
  output logic             irq
);

  logic [CRC_W-1:0] exp_q;

  always_ff @(posedge clk) begin
    if (rst)           exp_q <= '0;
    else if (exp_load) exp_q <= exp_value;
  end

  assign mismatch_evt = check && (result != exp_q);

  always_ff @(posedge clk) begin
    if (rst)               irq <= 1'b0;
    else if (mismatch_evt) irq <= 1'b1;
    else if (irq_clr)      irq <= 1'b0;
  end

  // R7: a mismatch raises the flag at the next edge
  a_r7_mismatch_sets: assert property (@(posedge clk) disable iff (rst)
    mismatch_evt |=> irq);

  // R8: the flag holds without a clear
  a_r8_irq_holds: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);

  // R8: a clear without a concurrent mismatch drops the flag
  a_r8_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && !mismatch_evt) |=> !irq);

  // R7: the flag only rises after a mismatch event
  a_r7_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(mismatch_evt));

endmodule

// File: rtl/crcw_engine.sv
module crcw_engine
  import crcw_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY   = 32'h04C1_1DB7,
  parameter logic [CRC_W-1:0] PRESET = 32'hFFFF_FFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CRC_W-1:0] in_data,
  input  logic             in_last,
  input  logic [CNT_W-1:0] in_bytes,
  input  logic             chk_en,
  input  logic             exp_load,
  input  logic [CRC_W-1:0] exp_value,
  input  logic             irq_clr,
  output logic             done,
  output logic [CRC_W-1:0] crc_out,
  output logic             irq
);

  crcw_state_e      state_q;
  logic             accept;
  logic             last_acc;
  logic [CRC_W-1:0] word_padded;
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] result_q;
  logic             mismatch_evt;

  assign in_ready = (state_q == ST_IDLE);
  assign done     = (state_q == ST_REPORT);
  assign accept   = in_valid && in_ready;
  assign last_acc = accept && in_last;

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else begin
      unique case (state_q)
        ST_IDLE:   if (last_acc) state_q <= ST_REPORT;
        ST_REPORT: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  crcw_pad u_pad (
    .word_in  (in_data),
    .last     (in_last),
    .cnt      (in_bytes),
    .word_out (word_padded)
  );

  crcw_core #(.POLY(POLY), .PRESET(PRESET)) u_core (
    .clk    (clk),
    .rst    (rst),
    .upd    (accept),
    .reload (done),
    .word   (word_padded),
    .crc_q  (crc_q)
  );

  always_ff @(posedge clk) begin
    if (rst)       result_q <= '0;
    else if (done) result_q <= crc_q;
  end

  assign crc_out = done ? crc_q : result_q;

  crcw_cmp u_cmp (
    .clk          (clk),
    .rst          (rst),
    .exp_load     (exp_load),
    .exp_value    (exp_value),
    .check        (done && chk_en),
    .result       (crc_q),
    .irq_clr      (irq_clr),
    .mismatch_evt (mismatch_evt),
    .irq          (irq)
  );

  // R5: done follows the accepted last word
  a_r5_done_after_last: assert property (@(posedge clk) disable iff (rst)
    last_acc |=> done);

  // R5: done lasts a single cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5: output holds between done pulses
  a_r5_out_holds: assert property (@(posedge clk) disable iff (rst)
    (!done && $past(!rst)) |-> $stable(crc_out));

  // R6: input is blocked in the cycle after the last word
  a_r6_ready_low: assert property (@(posedge clk) disable iff (rst)
    last_acc |=> !in_ready);

  // R6: input is open again after done
  a_r6_ready_back: assert property (@(posedge clk) disable iff (rst)
    done |=> in_ready);

endmodule

// File: tb/sim_crcw_engine.sv
module sim_crcw_engine;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_last, chk_en, exp_load, irq_clr;
  logic [31:0] in_data, exp_value;
  logic [1:0]  in_bytes;
  logic        in_ready, done, irq;
  logic [31:0] crc_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  logic [31:0] msg [0:7];

  always #4 clk = ~clk;

  crcw_engine u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_bytes(in_bytes),
    .chk_en(chk_en), .exp_load(exp_load), .exp_value(exp_value),
    .irq_clr(irq_clr), .done(done), .crc_out(crc_out), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Byte-serial reference: same polynomial, one byte at a time.
  function automatic logic [31:0] ref_bytes(input logic [31:0] crc, input logic [7:0] b);
    logic [31:0] c;
    c = crc ^ {b, 24'h0};
    for (int k = 0; k < 8; k++) c = c[31] ? ((c << 1) ^ 32'h04C11DB7) : (c << 1);
    return c;
  endfunction

  function automatic logic [31:0] ref_msg(input int n, input logic [1:0] lastb);
    logic [31:0] c;
    logic [31:0] w;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      w = msg[i];
      if (i == n - 1 && lastb != 0)
        for (int j = 0; j < 4; j++) if (j >= int'(lastb)) w[31-8*j -: 8] = 8'h00;
      for (int j = 0; j < 4; j++) c = ref_bytes(c, w[31-8*j -: 8]);
    end
    return c;
  endfunction

  // Sends msg[0..n-1]; returns at the negedge inside the done cycle.
  task automatic send(input int n, input logic [1:0] lastb, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = msg[i];
      in_last = (i == n - 1); in_bytes = (i == n - 1) ? lastb : 2'd3;
      @(posedge clk);
      if (gap > 0 && i < n - 1) begin
        @(negedge clk); in_valid = 0; in_data = 32'hDEAD_BEEF;
        for (int g = 1; g < gap; g++) @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 0; in_last = 0; in_data = 32'h0;
  endtask

  task automatic run_and_check(input int n, input logic [1:0] lastb, input int gap, input string tag);
    logic [31:0] e;
    e = ref_msg(n, lastb);
    send(n, lastb, gap);
    check(done === 1'b1, {tag, " R5 done"}, 32'(done), 32'd1);
    check(crc_out === e, {tag, " crc"}, crc_out, e);
    check(in_ready === 1'b0, {tag, " R6 ready low"}, 32'(in_ready), 32'd0);
    @(negedge clk);
    check(done === 1'b0, {tag, " R5 single pulse"}, 32'(done), 32'd0);
    check(crc_out === e, {tag, " R5 hold"}, crc_out, e);
    check(in_ready === 1'b1, {tag, " R6 ready back"}, 32'(in_ready), 32'd1);
  endtask

  task automatic t_reset();
    check(in_ready === 1'b1 && done === 1'b0, "R9 reset idle", {30'd0, in_ready, done}, 32'h2);
    check(irq === 1'b0, "R9 reset irq", 32'(irq), 32'd0);
    check(crc_out === 32'h0, "R5 R9 reset crc_out", crc_out, 32'h0);
  endtask

  task automatic t_single();
    msg[0] = 32'h3132_3334;
    run_and_check(1, 2'd0, 0, "R2 single word");
  endtask

  task automatic t_multi();
    msg[0] = 32'h0123_4567; msg[1] = 32'h89AB_CDEF; msg[2] = 32'hFFFF_0000;
    msg[3] = 32'h0000_0001; msg[4] = 32'hA5A5_5A5A;
    run_and_check(5, 2'd0, 0, "R2 multi back-to-back");
    run_and_check(5, 2'd0, 3, "R2 multi with gaps");
  endtask

  task automatic t_partial();
    msg[0] = 32'hCAFE_F00D; msg[1] = 32'h1122_3344; msg[2] = 32'h55AA_FF77;
    run_and_check(3, 2'd1, 0, "R3 one byte");
    run_and_check(3, 2'd2, 0, "R3 two bytes");
    run_and_check(3, 2'd3, 0, "R3 three bytes");
  endtask

  task automatic t_nolength();
    logic [31:0] a;
    msg[0] = 32'h9C77_7777;
    send(1, 2'd1, 0);
    a = crc_out;
    @(negedge clk);
    msg[0] = 32'h9C00_0000;
    send(1, 2'd0, 0);
    check(crc_out === a, "R4 same padded word same crc", crc_out, a);
    @(negedge clk);
  endtask

  task automatic t_preset();
    logic [31:0] a;
    msg[0] = 32'h7E57_0001; msg[1] = 32'h0BAD_C0DE;
    send(2, 2'd0, 0);
    a = crc_out;
    @(negedge clk);
    send(2, 2'd0, 0);
    check(crc_out === a && a === ref_msg(2, 2'd0), "R1 repeated message", crc_out, a);
    @(negedge clk);
  endtask

  task automatic t_ignored();
    logic [31:0] e;
    msg[0] = 32'h1357_9BDF;
    send(1, 2'd0, 0);
    in_valid = 1; in_data = 32'hFFFF_FFFF; in_last = 1; in_bytes = 0;
    @(negedge clk);
    in_valid = 0; in_last = 0;
    e = ref_msg(1, 2'd0);
    check(crc_out === e && done === 1'b0, "R6 no accept while ready low", crc_out, e);
    msg[0] = 32'h2468_ACE0;
    run_and_check(1, 2'd0, 0, "R6 next message clean");
  endtask

  task automatic t_compare();
    logic [31:0] e;
    msg[0] = 32'h4242_4242; msg[1] = 32'h0000_00FF;
    e = ref_msg(2, 2'd0);
    @(negedge clk); exp_load = 1; exp_value = e; @(negedge clk); exp_load = 0;
    chk_en = 1;
    send(2, 2'd0, 0); @(negedge clk);
    check(irq === 1'b0, "R7 match no irq", 32'(irq), 32'd0);
    @(negedge clk); exp_load = 1; exp_value = e ^ 32'h1; @(negedge clk); exp_load = 0;
    chk_en = 0;
    send(2, 2'd0, 0); @(negedge clk);
    check(irq === 1'b0, "R7 disabled no irq", 32'(irq), 32'd0);
    chk_en = 1;
    send(2, 2'd0, 0); @(negedge clk);
    check(irq === 1'b1, "R7 mismatch sets irq", 32'(irq), 32'd1);
    chk_en = 0;
    msg[0] = 32'h1111_2222;
    send(1, 2'd0, 0); @(negedge clk);
    check(irq === 1'b1, "R8 new message keeps irq", 32'(irq), 32'd1);
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    check(irq === 1'b0, "R8 clear drops irq", 32'(irq), 32'd0);
    chk_en = 1;
    send(1, 2'd0, 0);
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    check(irq === 1'b1, "R8 mismatch wins over clear", 32'(irq), 32'd1);
    chk_en = 0;
  endtask

  task automatic t_reset_mid();
    msg[0] = 32'hAAAA_AAAA; msg[1] = 32'hBBBB_BBBB;
    @(negedge clk); in_valid = 1; in_data = msg[0]; in_last = 0;
    @(negedge clk); in_valid = 0; rst = 1;
    @(negedge clk); rst = 0;
    check(irq === 1'b0, "R9 reset clears irq", 32'(irq), 32'd0);
    check(crc_out === 32'h0 && in_ready === 1'b1, "R9 reset idle mid-message", crc_out, 32'h0);
    run_and_check(2, 2'd0, 0, "R1 R9 preset after reset");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst = 1; in_valid = 0; in_data = 0; in_last = 0; in_bytes = 0;
    chk_en = 0; exp_load = 0; exp_value = 0; irq_clr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_partial();
    t_nolength();
    t_preset();
    t_ignored();
    t_compare();
    t_reset_mid();
    finish_run();
  end

endmodule